// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This block holds the 11-bit fetch address of a small core that runs one 14-bit instruction per clock. The decoder gives it one control strobe per instruction class. The block then forms the next address from one of these sources:

- a sequential step,
- a write of the PC register from the ALU,
- a short jump or short call that takes its page from the status register,
- a long jump or long call that carries a full target,
- a return that pops a two-entry hardware stack.

A skip request makes the block step past the next word.

Each slice of the address follows its own rule for each source. Bits 10–9 select a 512-word page. Bit 8 selects the half of that page. Bits 7–0 select the word. A short call forces bit 8 low, so it can only reach the lower half of the current page.

The stack is a three-state machine: STK_EMPTY, STK_ONE and STK_FULL. A push moves it EMPTY→ONE, ONE→FULL or FULL→FULL. In the last case the oldest entry is lost. A pop moves it FULL→ONE, ONE→EMPTY or EMPTY→EMPTY. The empty-to-empty pop is an underflow and returns the bottom slot unchanged. A source enum chooses the next address: SRC_INC, SRC_SKIP, SRC_PCW, SRC_SJMP, SRC_SCALL, SRC_LJMP, SRC_LCALL or SRC_RET.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted and after it is released, `fetch_addr` is 7FFh, `stk_depth` is 0 and `stk_top` is 0.
- R2: With no strobe and no skip, `fetch_addr` advances by one per clock and wraps from 7FFh to 000h.
- R3: A skip request with no control strobe advances `fetch_addr` by two, modulo 2048.
- R4: A PC-register write loads {page_sel, 0, alu_data[7:0]}.
- R5: A short jump loads {page_sel, ins_field[8], ins_field[7:0]}.
- R6: A short call loads {page_sel, 0, ins_field[7:0]} and pushes the call's own address plus one.
- R7: A long jump or long call loads ins_field[10:0]. A long call also pushes the call's own address plus one.
- R8: A return loads `stk_top` into the PC and decrements `stk_depth`. `stk_depth` reads 0 for empty, 1 for one entry and 2 for full.
- R9: A push at depth 2 keeps depth 2, makes the new value the top and discards the older of the two entries.
- R10: A return at depth 0 leaves depth 0 and loads the bottom slot, which still holds the value that was popped last.
- R11: Any control strobe takes priority over a simultaneous skip request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction per cycle |
| rst_n | input | 1 | Active-low reset (power-on, master clear or watchdog) |
| skip_req | input | 1 | Skip the next word |
| st_pcw | input | 1 | PC register written from ALU |
| st_sjmp | input | 1 | Short jump |
| st_scall | input | 1 | Short call |
| st_ljmp | input | 1 | Long jump |
| st_lcall | input | 1 | Long call |
| st_ret | input | 1 | Return (with or without immediate load) |
| ins_field | input | 11 | Target field of the instruction word |
| alu_data | input | 8 | ALU result for PC writes |
| page_sel | input | 2 | Page bits from the status register |
| fetch_addr | output | 11 | Current fetch address |
| stk_depth | output | 2 | Stack occupancy |
| stk_top | output | 11 | Top-of-stack entry |

## Verification
The assertions assume that at most one of the six control strobes is high in any cycle. They also assume that the decoder never raises a push and a pop together. The bench draws a single operation per cycle from $urandom, so no two strobes can be high at once. The only mixing it does is to pair a strobe with the skip request, which is the priority case R11 describes. Directed runs drive the stack into overflow and underflow and drive the address through its wrap at the top of memory.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        SRC_INC   = 3'd0,
        SRC_SKIP  = 3'd1,
        SRC_PCW   = 3'd2,
        SRC_SJMP  = 3'd3,
        SRC_SCALL = 3'd4,
        SRC_LJMP  = 3'd5,
        SRC_LCALL = 3'd6,
        SRC_RET   = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        STK_EMPTY = 2'd0,
        STK_ONE   = 2'd1,
        STK_FULL  = 2'd2
    } stk_st_e;

endpackage

// File: rtl/pcseq_nxt.sv
module pcseq_nxt
    import pcseq_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int LOW_W  = 8,
    localparam int PC_W  = PAGE_W + 1 + LOW_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic              skip_req,
    input  logic              st_pcw,
    input  logic              st_sjmp,
    input  logic              st_scall,
    input  logic              st_ljmp,
    input  logic              st_lcall,
    input  logic              st_ret,
    input  logic [PC_W-1:0]   ins_field,
    input  logic [LOW_W-1:0]  alu_data,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic [PC_W-1:0]   stk_top,
    output logic [PC_W-1:0]   nxt_pc,
    output logic              push,
    output logic              pop,
    output logic [PC_W-1:0]   push_val
);

    src_e             src;
    logic [PC_W-1:0]  pc_inc1;
    logic [PC_W-1:0]  pc_inc2;

    assign pc_inc1 = pc + PC_W'(1);
    assign pc_inc2 = pc + PC_W'(2);

    // Control-flow strobes win over the skip request.
    always_comb begin
        if (st_pcw)        src = SRC_PCW;
        else if (st_sjmp)  src = SRC_SJMP;
        else if (st_scall) src = SRC_SCALL;
        else if (st_ljmp)  src = SRC_LJMP;
        else if (st_lcall) src = SRC_LCALL;
        else if (st_ret)   src = SRC_RET;
        else if (skip_req) src = SRC_SKIP;
        else               src = SRC_INC;
    end

    // Each slice: page bits, half-page bit, word bits.
    always_comb begin
        unique case (src)
            SRC_PCW:   nxt_pc = {page_sel, 1'b0, alu_data};
            SRC_SJMP:  nxt_pc = {page_sel, ins_field[LOW_W], ins_field[LOW_W-1:0]};
            SRC_SCALL: nxt_pc = {page_sel, 1'b0, ins_field[LOW_W-1:0]};
            SRC_LJMP,
            SRC_LCALL: nxt_pc = ins_field;
            SRC_RET:   nxt_pc = stk_top;
            SRC_SKIP:  nxt_pc = pc_inc2;
            default:   nxt_pc = pc_inc1;
        endcase
    end

    assign push     = (src == SRC_SCALL) || (src == SRC_LCALL);
    assign pop      = (src == SRC_RET);
    assign push_val = pc_inc1;

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack
    import pcseq_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top,
    output logic [1:0]    depth
);

    stk_st_e       st_q, st_d;
    logic [AW-1:0] ent0_q, ent1_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= STK_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            STK_EMPTY: if (push) st_d = STK_ONE;
            STK_ONE:   if (push) st_d = STK_FULL;
                       else if (pop) st_d = STK_EMPTY;
            STK_FULL:  if (pop) st_d = STK_ONE;
            default:   st_d = STK_EMPTY;
        endcase
    end

    // Entries: push shifts down, a pop only shifts when two are held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent0_q <= '0;
            ent1_q <= '0;
        end else if (push) begin
            ent1_q <= ent0_q;
            ent0_q <= push_val;
        end else if (pop && st_q == STK_FULL) begin
            ent0_q <= ent1_q;
        end
    end

    // Outputs.
    assign top   = ent0_q;
    assign depth = st_q;

    AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        depth != 2'd3);                                                        // R8
    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top == $past(push_val));                                      // R6
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q == STK_FULL) |=> depth == 2'd2);                         // R9
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q == STK_EMPTY) |=> (depth == 2'd0 && $stable(top))); // R10

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PAGE_W = 2,
    parameter int LOW_W  = 8,
    localparam int PC_W  = PAGE_W + 1 + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              skip_req,
    input  logic              st_pcw,
    input  logic              st_sjmp,
    input  logic              st_scall,
    input  logic              st_ljmp,
    input  logic              st_lcall,
    input  logic              st_ret,
    input  logic [PC_W-1:0]   ins_field,
    input  logic [LOW_W-1:0]  alu_data,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [PC_W-1:0]   fetch_addr,
    output logic [1:0]        stk_depth,
    output logic [PC_W-1:0]   stk_top
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] nxt_pc;
    logic            push, pop;
    logic [PC_W-1:0] push_val;
    logic            any_cf;

    pcseq_nxt #(.PAGE_W(PAGE_W), .LOW_W(LOW_W)) u_nxt (
        .pc        (pc_q),
        .skip_req  (skip_req),
        .st_pcw    (st_pcw),
        .st_sjmp   (st_sjmp),
        .st_scall  (st_scall),
        .st_ljmp   (st_ljmp),
        .st_lcall  (st_lcall),
        .st_ret    (st_ret),
        .ins_field (ins_field),
        .alu_data  (alu_data),
        .page_sel  (page_sel),
        .stk_top   (stk_top),
        .nxt_pc    (nxt_pc),
        .push      (push),
        .pop       (pop),
        .push_val  (push_val)
    );

    pcseq_stack #(.AW(PC_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top      (stk_top),
        .depth    (stk_depth)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '1;
        else        pc_q <= nxt_pc;
    end

    assign fetch_addr = pc_q;
    assign any_cf = st_pcw | st_sjmp | st_scall | st_ljmp | st_lcall | st_ret;

    AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_pcw, st_sjmp, st_scall, st_ljmp, st_lcall, st_ret}));    // R11
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_cf && !skip_req) |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1))); // R2
    AST_SKIP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_cf && skip_req) |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(2)));  // R3
    AST_LONG_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ljmp || st_lcall) |=> fetch_addr == $past(ins_field));             // R7
    AST_RET_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        st_ret |=> fetch_addr == $past(stk_top));                              // R8
    AST_SCALL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_scall || st_pcw) |=> fetch_addr[LOW_W] == 1'b0);                   // R6

endmodule

// File: tb/tb_pcseq_top.sv
module tb_pcseq_top;

    localparam int OP_INC = 0, OP_PCW = 1, OP_SJMP = 2, OP_SCALL = 3,
                   OP_LJMP = 4, OP_LCALL = 5, OP_RET = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        skip_req = 1'b0;
    logic        st_pcw = 1'b0, st_sjmp = 1'b0, st_scall = 1'b0;
    logic        st_ljmp = 1'b0, st_lcall = 1'b0, st_ret = 1'b0;
    logic [10:0] ins_field = '0;
    logic [7:0]  alu_data = '0;
    logic [1:0]  page_sel = '0;
    logic [10:0] fetch_addr;
    logic [1:0]  stk_depth;
    logic [10:0] stk_top;

    int checks = 0;
    int errors = 0;

    logic [10:0] m_pc;
    logic [10:0] m_e0, m_e1;
    int          m_dep;

    always #10 clk = ~clk;

    pcseq_top dut (
        .clk(clk), .rst_n(rst_n), .skip_req(skip_req),
        .st_pcw(st_pcw), .st_sjmp(st_sjmp), .st_scall(st_scall),
        .st_ljmp(st_ljmp), .st_lcall(st_lcall), .st_ret(st_ret),
        .ins_field(ins_field), .alu_data(alu_data), .page_sel(page_sel),
        .fetch_addr(fetch_addr), .stk_depth(stk_depth), .stk_top(stk_top)
    );

    function automatic logic [10:0] exp_next(int op, logic sk, logic [10:0] pc,
                                             logic [10:0] ins, logic [7:0] alu,
                                             logic [1:0] pg, logic [10:0] top);
        case (op)
            OP_PCW:   return {pg, 1'b0, alu};
            OP_SJMP:  return {pg, ins[8:0]};
            OP_SCALL: return {pg, 1'b0, ins[7:0]};
            OP_LJMP,
            OP_LCALL: return ins;
            OP_RET:   return top;
            default:  return sk ? pc + 11'd2 : pc + 11'd1;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(int op, logic sk, logic [10:0] ins, logic [7:0] alu,
                        logic [1:0] pg, string req);
        logic [10:0] nx;
        skip_req = sk; ins_field = ins; alu_data = alu; page_sel = pg;
        st_pcw   = (op == OP_PCW);   st_sjmp  = (op == OP_SJMP);
        st_scall = (op == OP_SCALL); st_ljmp  = (op == OP_LJMP);
        st_lcall = (op == OP_LCALL); st_ret   = (op == OP_RET);
        nx = exp_next(op, sk, m_pc, ins, alu, pg, m_e0);
        if (op == OP_SCALL || op == OP_LCALL) begin
            m_e1 = m_e0; m_e0 = m_pc + 11'd1;
            if (m_dep < 2) m_dep++;
        end else if (op == OP_RET) begin
            if (m_dep == 2) m_e0 = m_e1;
            if (m_dep > 0) m_dep--;
        end
        m_pc = nx;
        @(negedge clk);
        chk(req, "fetch_addr", int'(fetch_addr), int'(m_pc));
        chk(req, "stk_depth", int'(stk_depth), m_dep);
        chk(req, "stk_top", int'(stk_top), int'(m_e0));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_pc = 11'h7FF; m_e0 = '0; m_e1 = '0; m_dep = 0;
        void'($urandom(32'h1234_5A5A));
        repeat (3) @(negedge clk);
        // R1: reset state while held and after release
        chk("R1", "fetch_addr", int'(fetch_addr), 'h7FF);
        chk("R1", "stk_depth", int'(stk_depth), 0);
        chk("R1", "stk_top", int'(stk_top), 0);
        rst_n = 1'b1;
        @(negedge clk);
        m_pc = 11'h000;   // first edge after release steps 7FF -> 000 (R2 wrap)
        chk("R1", "stk_depth", int'(stk_depth), 0);
        chk("R2", "fetch_addr wrap", int'(fetch_addr), 0);
        // R2 sequential
        step(OP_INC, 1'b0, '0, '0, '0, "R2");
        // R3 skip wrap: jump to 7FE, then skip gives 000
        step(OP_LJMP, 1'b0, 11'h7FE, '0, '0, "R7");
        step(OP_INC, 1'b1, '0, '0, '0, "R3");
        // R4 PC write forces bit 8 low
        step(OP_PCW, 1'b0, 11'h7FF, 8'hA5, 2'b11, "R4");
        // R5 short jump keeps bit 8 of the field
        step(OP_SJMP, 1'b0, 11'h1C3, '0, 2'b10, "R5");
        // R6 short call forces bit 8 low and pushes
        step(OP_SCALL, 1'b0, 11'h1FF, '0, 2'b01, "R6");
        // R9 overflow: two more calls
        step(OP_LCALL, 1'b0, 11'h555, '0, '0, "R7");
        step(OP_LCALL, 1'b0, 11'h2AA, '0, '0, "R9");
        // R8 returns, then R10 underflow twice
        step(OP_RET, 1'b0, '0, '0, '0, "R8");
        step(OP_RET, 1'b0, '0, '0, '0, "R8");
        step(OP_RET, 1'b0, '0, '0, '0, "R10");
        step(OP_RET, 1'b0, '0, '0, '0, "R10");
        // R11 strobe beats skip
        step(OP_LJMP, 1'b1, 11'h123, '0, '0, "R11");
        step(OP_SJMP, 1'b1, 11'h0FE, '0, 2'b01, "R11");
        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int          op;
            logic        sk;
            string       tag;
            op = int'($urandom_range(0, 6));
            sk = ($urandom_range(0, 3) == 0);
            case (op)
                OP_PCW:   tag = "R4";
                OP_SJMP:  tag = "R5";
                OP_SCALL: tag = (m_dep == 2) ? "R9" : "R6";
                OP_LJMP:  tag = "R7";
                OP_LCALL: tag = (m_dep == 2) ? "R9" : "R7";
                OP_RET:   tag = (m_dep == 0) ? "R10" : "R8";
                default:  tag = sk ? "R3" : "R2";
            endcase
            if (sk && op != OP_INC) tag = "R11";
            step(op, sk, 11'($urandom), 8'($urandom), 2'($urandom), tag);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule